// File: doc/BRIEF.md
# Scatter-Gather DMA Channel

This block is one memory-to-memory DMA channel driven by a chain of descriptors held in memory. Software places the descriptors, writes the destination start address and the address of the first descriptor, and then enables the channel. The channel reads a descriptor and copies the buffer it describes one word at a time. It then stamps the descriptor as done and follows the link to the next descriptor. A null link ends the chain.

The source address comes fresh from every descriptor. The destination address is set only by software, so the buffers of one chain land back to back. Each descriptor still holds a destination word, which the channel reads and discards. Status bits report buffer and chain completion, and an interrupt line is raised for the status bits that software has unmasked. All memory traffic goes through one word-wide master port with a request/grant handshake.

Top module: `sg_dma_chan`

## Requirements
- R1: The channel issues no memory request until both the global enable (register 0, bit 0) and the channel enable (register 1, bit 0) are 1. It then starts reading at the descriptor pointer held in register 2.
- R2: A descriptor is five words at byte offsets 0, 4, 8, 12 and 16 from its pointer, read in that order. Offset 0 is the source start, 8 is the link, 12 is control A with the buffer length in words in bits [15:0], and 16 is control B.
- R3: The destination word at offset 4 is read but never loaded. The destination address (register 3) continues from where the previous buffer stopped.
- R4: After the last data word of a buffer, control A with bit 31 set is written back to the descriptor pointer plus 12.
- R5: A non-zero link makes the channel fetch the next descriptor. A zero link ends the chain after that buffer, and the channel enable bit then reads 0.
- R6: Control B bits [1:0] select the source stepping and bits [5:4] select the destination stepping. The value 0 adds 4 per word, 1 subtracts 4, and 2 or 3 keeps the address fixed. The current source address reads at register 6.
- R7: The status register 4 has bit 0 for buffer complete and bit 1 for chain complete. Both bits are sticky and are cleared by a read of register 4.
- R8: The irq output is high exactly when a status bit is set whose matching bit in the mask register 5 (bits [1:0]) is 1.
- R9: Writing 0 to the channel enable while a buffer is being copied stops the channel once the current word has been written. No write-back is done and no status bit is set.
- R10: A memory request keeps its address, direction and write data unchanged until it is granted.
- R11: A descriptor of length 0 moves no data and goes straight to its write-back.
- R12: After reset, registers 0 to 6 all read 0 and irq is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_re | input | 1 | Register read strobe (clears status on register 4) |
| cfg_idx | input | 4 | Register index |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data, combinational from cfg_idx |
| mem_req | output | 1 | Memory access request |
| mem_gnt | input | 1 | Memory grant; the access completes in a cycle with req and gnt both high |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W | Byte address of the word |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid in the granted cycle |
| irq | output | 1 | Masked OR of the status bits |

## Verification
Register read data is combinational and is sampled in the same cycle as the read strobe. The status clear takes effect at the following edge. A status bit and irq rise one cycle after the granted write-back. Chain length depends on grant stalls, so the bench does not count to a fixed cycle. It waits for irq with a bounded poll, then inspects memory and registers in a later cycle, always in the middle of the clock period. The stop case is checked only after a quiet gap of ten cycles, because the halt waits for the current word's write to complete.

// File: rtl/sg_dma_pkg.sv
package sg_dma_pkg;
    localparam int WORD_W     = 32;
    localparam int WORD_BYTES = WORD_W / 8;
    localparam int DESC_WORDS = 5;
    localparam int SLOT_SRC   = 0;
    localparam int SLOT_DST   = 1;
    localparam int SLOT_LINK  = 2;
    localparam int SLOT_CTLA  = 3;
    localparam int SLOT_CTLB  = 4;
    localparam int DONE_BIT   = 31;
    localparam int SRC_MODE_LSB = 0;
    localparam int DST_MODE_LSB = 4;

    typedef enum logic [3:0] {
        RG_GLOBAL = 4'd0,
        RG_CHAN   = 4'd1,
        RG_DESC   = 4'd2,
        RG_DST    = 4'd3,
        RG_STAT   = 4'd4,
        RG_MASK   = 4'd5,
        RG_SRC    = 4'd6
    } reg_idx_e;

    typedef enum logic [2:0] {
        ST_IDLE, ST_FETCH, ST_READ, ST_WRITE, ST_WBACK
    } eng_state_e;

    typedef enum logic [1:0] {
        STEP_UP = 2'd0, STEP_DOWN = 2'd1, STEP_HOLD = 2'd2, STEP_HOLD_ALT = 2'd3
    } step_e;

    typedef struct packed {
        logic chain;
        logic buf_done;
    } stat_t;

    function automatic logic [WORD_W-1:0] slot_offset(input int slot);
        return WORD_W'(slot * WORD_BYTES);
    endfunction
endpackage

// File: rtl/sg_dma_addr_unit.sv
module sg_dma_addr_unit import sg_dma_pkg::*; #(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ld,
    input  logic [ADDR_W-1:0] ld_val,
    input  logic              step,
    input  step_e             mode,
    output logic [ADDR_W-1:0] addr
);
    localparam logic [ADDR_W-1:0] STRIDE = ADDR_W'(WORD_BYTES);

    always_ff @(posedge clk) begin
        if (rst) begin
            addr <= '0;
        end else if (ld) begin
            addr <= ld_val;
        end else if (step) begin
            case (mode)
                STEP_UP:   addr <= addr + STRIDE;
                STEP_DOWN: addr <= addr - STRIDE;
                default:   addr <= addr;
            endcase
        end
    end
endmodule

// File: rtl/sg_dma_regs.sv
module sg_dma_regs import sg_dma_pkg::*; #(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic              cfg_re,
    input  logic [3:0]        cfg_idx,
    input  logic [WORD_W-1:0] cfg_wdata,
    output logic [WORD_W-1:0] cfg_rdata,
    input  logic [ADDR_W-1:0] src_now,
    input  logic [ADDR_W-1:0] dst_now,
    input  logic              buf_evt,
    input  logic              chain_evt,
    output logic              glob_en,
    output logic              chan_en,
    output logic [ADDR_W-1:0] desc_ptr,
    output logic              dst_wr,
    output logic              irq
);
    stat_t      stat_q, stat_d;
    logic [1:0] mask_q;

    function automatic logic hit(input logic [3:0] idx, input reg_idx_e which);
        return idx == which;
    endfunction

    always_comb begin
        stat_d = (cfg_re && hit(cfg_idx, RG_STAT)) ? '0 : stat_q;
        if (buf_evt)   stat_d.buf_done = 1'b1;
        if (chain_evt) stat_d.chain    = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            glob_en  <= 1'b0;
            chan_en  <= 1'b0;
            desc_ptr <= '0;
            mask_q   <= '0;
            stat_q   <= '0;
        end else begin
            stat_q <= stat_d;
            if (cfg_we && hit(cfg_idx, RG_GLOBAL)) glob_en <= cfg_wdata[0];
            if (cfg_we && hit(cfg_idx, RG_CHAN))   chan_en <= cfg_wdata[0];
            else if (chain_evt)                    chan_en <= 1'b0;
            if (cfg_we && hit(cfg_idx, RG_DESC))   desc_ptr <= cfg_wdata[ADDR_W-1:0];
            if (cfg_we && hit(cfg_idx, RG_MASK))   mask_q <= cfg_wdata[1:0];
        end
    end

    assign dst_wr = cfg_we && hit(cfg_idx, RG_DST);
    assign irq    = |(stat_q & mask_q);

    always_comb begin
        case (cfg_idx)
            RG_GLOBAL: cfg_rdata = WORD_W'(glob_en);
            RG_CHAN:   cfg_rdata = WORD_W'(chan_en);
            RG_DESC:   cfg_rdata = WORD_W'(desc_ptr);
            RG_DST:    cfg_rdata = WORD_W'(dst_now);
            RG_STAT:   cfg_rdata = WORD_W'(stat_q);
            RG_MASK:   cfg_rdata = WORD_W'(mask_q);
            RG_SRC:    cfg_rdata = WORD_W'(src_now);
            default:   cfg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/sg_dma_engine.sv
module sg_dma_engine import sg_dma_pkg::*; #(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic [ADDR_W-1:0] desc_ptr,
    input  logic              dst_wr,
    input  logic [ADDR_W-1:0] dst_wval,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic              mem_gnt,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic [ADDR_W-1:0] src_now,
    output logic [ADDR_W-1:0] dst_now,
    output logic              buf_evt,
    output logic              chain_evt,
    output eng_state_e        state
);
    localparam int IDX_W = $clog2(DESC_WORDS);

    logic [ADDR_W-1:0] cur_ptr, link_q;
    logic [WORD_W-1:0] ctl_a, ctl_b, data_q;
    logic [IDX_W-1:0]  widx;
    logic [LEN_W-1:0]  remain;
    logic              xfer;

    assign xfer = mem_req && mem_gnt;

    sg_dma_addr_unit #(.ADDR_W(ADDR_W)) i_src (
        .clk(clk), .rst(rst),
        .ld(state == ST_FETCH && xfer && widx == IDX_W'(SLOT_SRC)),
        .ld_val(mem_rdata[ADDR_W-1:0]),
        .step(state == ST_READ && xfer),
        .mode(step_e'(ctl_b[SRC_MODE_LSB +: 2])),
        .addr(src_now)
    );

    sg_dma_addr_unit #(.ADDR_W(ADDR_W)) i_dst (
        .clk(clk), .rst(rst),
        .ld(dst_wr && state == ST_IDLE),
        .ld_val(dst_wval),
        .step(state == ST_WRITE && xfer),
        .mode(step_e'(ctl_b[DST_MODE_LSB +: 2])),
        .addr(dst_now)
    );

    always_comb begin
        mem_req   = state != ST_IDLE;
        mem_we    = (state == ST_WRITE) || (state == ST_WBACK);
        mem_addr  = '0;
        mem_wdata = '0;
        case (state)
            ST_FETCH: mem_addr = cur_ptr + ADDR_W'(widx) * ADDR_W'(WORD_BYTES);
            ST_READ:  mem_addr = src_now;
            ST_WRITE: begin
                mem_addr  = dst_now;
                mem_wdata = data_q;
            end
            ST_WBACK: begin
                mem_addr  = cur_ptr + ADDR_W'(slot_offset(SLOT_CTLA));
                mem_wdata = ctl_a | (WORD_W'(1) << DONE_BIT);
            end
            default: ;
        endcase
    end

    assign buf_evt   = state == ST_WBACK && xfer;
    assign chain_evt = buf_evt && link_q == '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            cur_ptr <= '0;
            link_q  <= '0;
            ctl_a   <= '0;
            ctl_b   <= '0;
            data_q  <= '0;
            widx    <= '0;
            remain  <= '0;
        end else begin
            case (state)
                ST_IDLE: if (run) begin
                    cur_ptr <= desc_ptr;
                    widx    <= '0;
                    state   <= ST_FETCH;
                end
                ST_FETCH: if (xfer) begin
                    if (widx == IDX_W'(SLOT_LINK)) link_q <= mem_rdata[ADDR_W-1:0];
                    if (widx == IDX_W'(SLOT_CTLA)) begin
                        ctl_a  <= mem_rdata;
                        remain <= mem_rdata[LEN_W-1:0];
                    end
                    if (widx == IDX_W'(SLOT_CTLB)) begin
                        ctl_b <= mem_rdata;
                        if (!run)             state <= ST_IDLE;
                        else if (remain == '0) state <= ST_WBACK;
                        else                  state <= ST_READ;
                    end else if (!run) begin
                        state <= ST_IDLE;
                    end else begin
                        widx <= widx + 1'b1;
                    end
                end
                ST_READ: if (xfer) begin
                    data_q <= mem_rdata;
                    state  <= ST_WRITE;
                end
                ST_WRITE: if (xfer) begin
                    remain <= remain - 1'b1;
                    if (!run)              state <= ST_IDLE;
                    else if (remain == 'd1) state <= ST_WBACK;
                    else                   state <= ST_READ;
                end
                ST_WBACK: if (xfer) begin
                    if (link_q == '0 || !run) begin
                        state <= ST_IDLE;
                    end else begin
                        cur_ptr <= link_q;
                        widx    <= '0;
                        state   <= ST_FETCH;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/sg_dma_chan.sv
module sg_dma_chan import sg_dma_pkg::*; #(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic              cfg_re,
    input  logic [3:0]        cfg_idx,
    input  logic [31:0]       cfg_wdata,
    output logic [31:0]       cfg_rdata,
    output logic              mem_req,
    input  logic              mem_gnt,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic [31:0]       mem_rdata,
    output logic              irq
);
    logic              glob_en, chan_en, dst_wr, buf_evt, chain_evt;
    logic [ADDR_W-1:0] desc_ptr, src_now, dst_now;
    eng_state_e        eng_state;

    sg_dma_regs #(.ADDR_W(ADDR_W)) i_regs (
        .clk(clk), .rst(rst),
        .cfg_we(cfg_we), .cfg_re(cfg_re), .cfg_idx(cfg_idx),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .src_now(src_now), .dst_now(dst_now),
        .buf_evt(buf_evt), .chain_evt(chain_evt),
        .glob_en(glob_en), .chan_en(chan_en), .desc_ptr(desc_ptr),
        .dst_wr(dst_wr), .irq(irq)
    );

    sg_dma_engine #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) i_eng (
        .clk(clk), .rst(rst),
        .run(glob_en && chan_en),
        .desc_ptr(desc_ptr),
        .dst_wr(dst_wr), .dst_wval(cfg_wdata[ADDR_W-1:0]),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_gnt(mem_gnt), .mem_rdata(mem_rdata),
        .src_now(src_now), .dst_now(dst_now),
        .buf_evt(buf_evt), .chain_evt(chain_evt),
        .state(eng_state)
    );
endmodule

// File: rtl/sg_dma_chk.sv
module sg_dma_chk import sg_dma_pkg::*; #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              mem_req,
    input logic              mem_gnt,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [31:0]       mem_wdata,
    input eng_state_e        eng_state,
    input logic [ADDR_W-1:0] dst_now,
    input logic              glob_en,
    input logic              chan_en,
    input logic              chain_evt
);
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        eng_state == ST_IDLE |-> !mem_req); // R1
    AST_NO_START_UNGATED: assert property (@(posedge clk) disable iff (rst)
        (eng_state == ST_IDLE && !glob_en) |=> eng_state == ST_IDLE); // R1
    AST_DST_KEPT_IN_FETCH: assert property (@(posedge clk) disable iff (rst)
        eng_state == ST_FETCH |=> $stable(dst_now)); // R3
    AST_WBACK_MARKED: assert property (@(posedge clk) disable iff (rst)
        (eng_state == ST_WBACK && mem_req) |-> (mem_we && mem_wdata[DONE_BIT])); // R4
    AST_CHAIN_END_CLEARS: assert property (@(posedge clk) disable iff (rst)
        chain_evt |=> !chan_en); // R5
    AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata))); // R10
endmodule

bind sg_dma_chan sg_dma_chk #(.ADDR_W(ADDR_W)) i_chk (
    .clk(clk), .rst(rst),
    .mem_req(mem_req), .mem_gnt(mem_gnt), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .eng_state(eng_state), .dst_now(dst_now),
    .glob_en(glob_en), .chan_en(chan_en), .chain_evt(chain_evt)
);

// File: tb/test_sg_dma_chan.sv
module test_sg_dma_chan;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0, cfg_re = 1'b0;
    logic [3:0]  cfg_idx = '0;
    logic [31:0] cfg_wdata = '0, cfg_rdata;
    logic        mem_req, mem_gnt, mem_we, irq;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;

    logic [31:0] mem [0:1023];
    logic        tb_we = 1'b0;
    logic [31:0] tb_a = '0, tb_d = '0;
    logic        stall_on = 1'b0;
    logic [1:0]  stall_cnt = '0;

    int n_chk = 0;
    int n_err = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign mem_rdata = mem[mem_addr[11:2]];
    assign mem_gnt   = mem_req && (!stall_on || stall_cnt == 2'b11);

    always @(posedge clk) begin
        stall_cnt <= stall_cnt + 2'd1;
        if (tb_we) mem[tb_a[11:2]] <= tb_d;
        else if (mem_req && mem_gnt && mem_we) mem[mem_addr[11:2]] <= mem_wdata;
    end

    sg_dma_chan i_sg_dma_chan (
        .clk(clk), .rst(rst),
        .cfg_we(cfg_we), .cfg_re(cfg_re), .cfg_idx(cfg_idx),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .mem_req(mem_req), .mem_gnt(mem_gnt), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .irq(irq)
    );

    function automatic logic [31:0] srcval(input logic [31:0] a);
        return 32'h5A00_0000 | a;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic poke(input logic [31:0] a, input logic [31:0] d);
        tb_we = 1'b1; tb_a = a; tb_d = d;
        @(posedge clk); #1;
        tb_we = 1'b0;
    endtask

    task automatic put_desc(input logic [31:0] at, input logic [31:0] src,
                            input logic [31:0] dst, input logic [31:0] link,
                            input logic [31:0] ca, input logic [31:0] cb);
        poke(at, src); poke(at + 4, dst); poke(at + 8, link);
        poke(at + 12, ca); poke(at + 16, cb);
    endtask

    task automatic wr(input logic [3:0] idx, input logic [31:0] d);
        cfg_we = 1'b1; cfg_idx = idx; cfg_wdata = d;
        @(posedge clk); #1;
        cfg_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] idx, output logic [31:0] v);
        cfg_re = 1'b1; cfg_idx = idx;
        #1 v = cfg_rdata;
        @(posedge clk); #1;
        cfg_re = 1'b0;
    endtask

    task automatic wait_irq(input string tag);
        int n = 0;
        while (!irq && n < 3000) begin
            @(posedge clk); #1;
            n++;
        end
        chk(tag, {31'b0, irq}, 32'd1);
    endtask

    task automatic t_reset;
        logic [31:0] v;
        for (int i = 0; i < 7; i++) begin
            rd(4'(i), v);
            chk($sformatf("R12 reset reg %0d", i), v, 32'd0);
        end
        chk("R12 reset irq", {31'b0, irq}, 32'd0);
    endtask

    task automatic t_gate;
        logic saw = 1'b0;
        put_desc(32'h1A0, 32'h200, 32'h0, 32'h0, 32'd1, 32'h0);
        wr(4'd2, 32'h1A0);
        wr(4'd1, 32'd1);
        repeat (20) begin
            @(posedge clk); #1;
            if (mem_req) saw = 1'b1;
        end
        chk("R1 no request without global enable", {31'b0, saw}, 32'd0);
        wr(4'd1, 32'd0);
    endtask

    task automatic t_chain;
        logic [31:0] v;
        for (int k = 0; k < 8; k++) poke(32'h400 + 4*k, 32'h0);
        put_desc(32'h100, 32'h200, 32'hDEAD_0000, 32'h140, 32'd3, 32'h00);
        put_desc(32'h140, 32'h300, 32'hBEEF_0000, 32'h000, 32'd2, 32'h01);
        wr(4'd3, 32'h400);
        wr(4'd0, 32'd1);
        wr(4'd5, 32'd2);
        wr(4'd2, 32'h100);
        wr(4'd1, 32'd1);
        wait_irq("R8 chain irq");
        chk("R2 buf1 word0", mem[32'h400 >> 2], srcval(32'h200));
        chk("R2 buf1 word1", mem[32'h404 >> 2], srcval(32'h204));
        chk("R2 buf1 word2", mem[32'h408 >> 2], srcval(32'h208));
        chk("R3 buf2 word0 contiguous", mem[32'h40C >> 2], srcval(32'h300));
        chk("R6 buf2 word1 decrement", mem[32'h410 >> 2], srcval(32'h2FC));
        chk("R5 nothing past chain end", mem[32'h414 >> 2], 32'h0);
        chk("R4 write-back desc1", mem[32'h10C >> 2], 32'h8000_0003);
        chk("R4 write-back desc2", mem[32'h14C >> 2], 32'h8000_0002);
        chk("R3 desc dst word untouched", mem[32'h104 >> 2], 32'hDEAD_0000);
        rd(4'd3, v); chk("R3 dst register runs on", v, 32'h414);
        rd(4'd6, v); chk("R6 src register after decrement", v, 32'h2F8);
        rd(4'd1, v); chk("R5 channel enable self-cleared", v, 32'd0);
        rd(4'd4, v); chk("R7 status both bits", v, 32'd3);
        rd(4'd4, v); chk("R7 status cleared by read", v, 32'd0);
        chk("R8 irq low after clear", {31'b0, irq}, 32'd0);
    endtask

    task automatic t_fixed_stall;
        logic [31:0] v;
        poke(32'h500, 32'h0); poke(32'h504, 32'h0);
        put_desc(32'h180, 32'h200, 32'h1111_1111, 32'h0, 32'd3, 32'h20);
        wr(4'd3, 32'h500);
        wr(4'd2, 32'h180);
        stall_on = 1'b1;
        wr(4'd1, 32'd1);
        wait_irq("R10 stalled chain irq");
        stall_on = 1'b0;
        chk("R6 fixed dst holds last word", mem[32'h500 >> 2], srcval(32'h208));
        chk("R6 fixed dst no spill", mem[32'h504 >> 2], 32'h0);
        chk("R10 write-back under stalls", mem[32'h18C >> 2], 32'h8000_0003);
        rd(4'd3, v); chk("R6 fixed dst register", v, 32'h500);
        rd(4'd6, v); chk("R6 src incremented", v, 32'h20C);
        rd(4'd4, v); chk("R7 status after stalled run", v, 32'd3);
    endtask

    task automatic t_zero;
        logic [31:0] v;
        poke(32'h600, 32'h0);
        put_desc(32'h1C0, 32'h200, 32'h0, 32'h0, 32'd0, 32'h0);
        wr(4'd3, 32'h600);
        wr(4'd5, 32'd1);
        wr(4'd2, 32'h1C0);
        wr(4'd1, 32'd1);
        wait_irq("R8 buffer-mask irq");
        chk("R11 zero-length write-back", mem[32'h1CC >> 2], 32'h8000_0000);
        chk("R11 no data written", mem[32'h600 >> 2], 32'h0);
        rd(4'd3, v); chk("R11 dst unchanged", v, 32'h600);
        rd(4'd4, v); chk("R7 status zero-length", v, 32'd3);
        chk("R8 irq cleared", {31'b0, irq}, 32'd0);
    endtask

    task automatic t_stop;
        logic [31:0] v, d;
        for (int k = 0; k < 64; k++) poke(32'h700 + 4*k, 32'h0);
        put_desc(32'h1E0, 32'h200, 32'h0, 32'h0, 32'd40, 32'h0);
        wr(4'd3, 32'h700);
        wr(4'd5, 32'd3);
        wr(4'd2, 32'h1E0);
        wr(4'd1, 32'd1);
        repeat (15) @(posedge clk);
        #1;
        wr(4'd1, 32'd0);
        repeat (10) @(posedge clk);
        #1;
        chk("R9 no request after stop", {31'b0, mem_req}, 32'd0);
        chk("R9 no write-back after stop", mem[32'h1EC >> 2], 32'd40);
        chk("R9 no irq after stop", {31'b0, irq}, 32'd0);
        rd(4'd4, v); chk("R9 no status after stop", v, 32'd0);
        rd(4'd3, d);
        chk("R9 stopped part way", {31'b0, (d > 32'h700 && d < 32'h7A0)}, 32'd1);
        chk("R9 last copied word", mem[(d - 4) >> 2], srcval(32'h200 + (d - 4 - 32'h700)));
        chk("R9 no word beyond stop", mem[d >> 2], 32'h0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_err++;
        $display("FAIL watchdog act=hung exp=done");
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        t_reset();
        for (int a = 32'h200; a <= 32'h300; a += 4) poke(a, srcval(a));
        poke(32'h2F8, srcval(32'h2F8));
        t_gate();
        t_chain();
        t_fixed_stall();
        t_zero();
        t_stop();
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule